// File: doc/BRIEF.md
# Accumulator ALU with B-Register Multiply and Divide

This block is the 8-bit arithmetic and logic unit of a small accumulator machine. Each operation takes an accumulator value, a second operand, a B-register value and the incoming carry, auxiliary-carry and overflow flags. It returns a new accumulator value, a new B value and the three updated flags. The operation set covers:

- addition, with or without carry-in, and subtraction with borrow
- increment and decrement
- bitwise AND, OR and XOR, complement and clear
- plain rotates and rotates through carry, and nibble swap
- decimal adjust after a BCD addition
- unsigned multiply and divide

The caller raises `start` for one cycle with the inputs valid. Most operations finish in one cycle. Multiply and divide use a shift-and-add or shift-and-subtract engine that takes one step per bit. While that engine runs, `busy` is high and further starts are ignored. Every result arrives with a single-cycle `done` pulse. The outputs keep their values until the next `done`.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (plain add) sets `acc_out` to the low 8 bits of acc_in+opnd_in and ignores `cy_in`. Code 1 (add with carry) also adds `cy_in`. For both, `cy_out` is the carry out of bit 7.
- R2: Operation code 2 (subtract with borrow) sets `acc_out` to acc_in−opnd_in−cy_in, modulo 256. `cy_out` is 1 exactly when a borrow leaves bit 7.
- R3: For codes 0, 1 and 2, `ac_out` is the carry (or the borrow) out of bit 3. `ov_out` is 1 when the two's-complement result falls outside −128..127.
- R4: Code 3 (increment) wraps 0xFF to 0x00 and code 4 (decrement) wraps 0x00 to 0xFF. Both copy `cy_in`, `ac_in` and `ov_in` unchanged to the flag outputs.
- R5: Code 5 (multiply) forms the 16-bit product acc_in×b_in. The low byte goes to `acc_out` and the high byte to `b_out`. `cy_out` and `ac_out` are 0, and `ov_out` is 1 exactly when the high byte is nonzero.
- R6: Code 6 (divide) places the quotient acc_in/b_in in `acc_out` and the remainder in `b_out`. All three flags are 0.
- R7: Divide with b_in = 0 returns `acc_out` equal to acc_in and `b_out` equal to 0. `ov_out` is 1, and `cy_out` and `ac_out` are 0. `done` comes two cycles after the start edge.
- R8: Code 7 (decimal adjust) works in two steps. First it adds 0x06 when bits 3:0 exceed 9 or `ac_in` is 1. Then it adds 0x60 when bits 7:4 of that sum exceed 9 or a carry is pending (`cy_in`, or a carry from the first step). `cy_out` is 1 when the input carry or either addition carries out of bit 7. `ac_out` and `ov_out` copy their inputs.
- R9: Codes 8, 9 and 10 give acc_in AND, OR and XOR opnd_in. Code 11 gives the bitwise complement (255 minus acc_in), and code 12 gives 0. All five leave the flags equal to their inputs.
- R10: Code 13 rotates left with bit 7 entering bit 0, and code 15 rotates right with bit 0 entering bit 7; both keep `cy_in`. Code 14 rotates left through carry (bit 7 goes to `cy_out`, `cy_in` goes to bit 0). Code 16 rotates right through carry (bit 0 goes to `cy_out`, `cy_in` goes to bit 7).
- R11: Code 17 exchanges bits 3:0 with bits 7:4 of acc_in.
- R12: A start edge for a single-cycle code gives `done` in the following cycle. A start for codes 5 or 6 with a nonzero divisor gives `done` W+2 cycles after the start edge. `busy` is high from the start edge until the result is registered. A start while `busy` is high has no effect.
- R13: Every code other than 5 and 6 sets `b_out` to b_in. Codes 18 to 31 return acc_in and all flags unchanged.
- R14: After reset, every data and flag output is 0, and `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the operation on the current inputs |
| op | input | 5 | Operation code |
| acc_in | input | W | Accumulator operand (dividend, multiplicand) |
| opnd_in | input | W | Second operand for add, subtract and logic |
| b_in | input | W | B-register operand (multiplier, divisor) |
| cy_in | input | 1 | Carry flag in |
| ac_in | input | 1 | Auxiliary carry flag in |
| ov_in | input | 1 | Overflow flag in |
| acc_out | output | W | New accumulator value |
| b_out | output | W | New B value |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |
| done | output | 1 | One-cycle pulse: outputs updated |
| busy | output | 1 | Multi-cycle operation in progress |

## Verification
The bench pushes addition and subtraction through the operand pairs where the carry, the half carry and the signed overflow part ways, for example 0x7F+0x01 and 0x80−0x01. A design that took the half carry from the wrong bit, or left the carry-in out of the borrow, fails there. Multiply runs on 0xFF×0xFF, and divide runs with a remainder, with a quotient of zero and with a zero divisor. A divider that does not restore, or that writes garbage on a zero divisor, returns wrong B values. A start held high while the engine is busy would cause an extra `done` or a corrupted product if the design accepted it. The decimal-adjust cases that need both corrections, or only the carry-driven upper one, catch an adjust that tests the wrong nibble.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADDC = 5'd1,
        OP_SUBB = 5'd2,
        OP_INC  = 5'd3,
        OP_DEC  = 5'd4,
        OP_MUL  = 5'd5,
        OP_DIV  = 5'd6,
        OP_DADJ = 5'd7,
        OP_AND  = 5'd8,
        OP_OR   = 5'd9,
        OP_XOR  = 5'd10,
        OP_CPL  = 5'd11,
        OP_CLR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROLC = 5'd14,
        OP_ROR  = 5'd15,
        OP_RORC = 5'd16,
        OP_SWAP = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   o,
    input  alu_flags_t     fi,
    output logic [W-1:0]   r,
    output alu_flags_t     fo
);
    localparam int H = W / 2;

    logic           cin_add;
    logic [W:0]     sum_w;
    logic [W:0]     dif_w;
    logic [H:0]     hsum_w;
    logic [H:0]     hdif_w;
    logic [W-1:0]   da_r;
    logic           da_cy;

    always_comb begin
        cin_add = (op == OP_ADDC) ? fi.cy : 1'b0;
        sum_w   = {1'b0, a} + {1'b0, o} + (W+1)'(cin_add);
        hsum_w  = {1'b0, a[H-1:0]} + {1'b0, o[H-1:0]} + (H+1)'(cin_add);
        dif_w   = {1'b0, a} - {1'b0, o} - (W+1)'(fi.cy);
        hdif_w  = {1'b0, a[H-1:0]} - {1'b0, o[H-1:0]} - (H+1)'(fi.cy);
    end

    // Decimal adjust is defined on two 4-bit digits only.
    generate
        if (W == 8) begin : g_dadj
            logic       lo_fix;
            logic       hi_fix;
            logic       c1;
            logic [8:0] t1;
            logic [8:0] t2;
            always_comb begin
                lo_fix = (a[3:0] > 4'd9) || fi.ac;
                t1     = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
                c1     = fi.cy | t1[8];
                hi_fix = (t1[7:4] > 4'd9) || c1;
                t2     = {1'b0, t1[7:0]} + (hi_fix ? 9'h060 : 9'h000);
                da_r   = t2[7:0];
                da_cy  = c1 | t2[8];
            end
        end else begin : g_no_dadj
            assign da_r  = a;
            assign da_cy = fi.cy;
        end
    endgenerate

    always_comb begin
        r  = a;
        fo = fi;
        case (op)
            OP_ADD, OP_ADDC: begin
                r     = sum_w[W-1:0];
                fo.cy = sum_w[W];
                fo.ac = hsum_w[H];
                fo.ov = (a[W-1] == o[W-1]) && (sum_w[W-1] != a[W-1]);
            end
            OP_SUBB: begin
                r     = dif_w[W-1:0];
                fo.cy = dif_w[W];
                fo.ac = hdif_w[H];
                fo.ov = (a[W-1] != o[W-1]) && (dif_w[W-1] != a[W-1]);
            end
            OP_INC:  r = a + W'(1);
            OP_DEC:  r = a - W'(1);
            OP_DADJ: begin
                r     = da_r;
                fo.cy = da_cy;
            end
            default: begin
                r  = a;
                fo = fi;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   o,
    input  alu_flags_t     fi,
    output logic [W-1:0]   r,
    output alu_flags_t     fo
);
    localparam int H = W / 2;

    always_comb begin
        r  = a;
        fo = fi;
        case (op)
            OP_AND:  r = a & o;
            OP_OR:   r = a | o;
            OP_XOR:  r = a ^ o;
            OP_CPL:  r = ~a;
            OP_CLR:  r = '0;
            OP_ROL:  r = {a[W-2:0], a[W-1]};
            OP_ROR:  r = {a[0], a[W-1:1]};
            OP_ROLC: begin
                r     = {a[W-2:0], fi.cy};
                fo.cy = a[W-1];
            end
            OP_RORC: begin
                r     = {fi.cy, a[W-1:1]};
                fo.cy = a[0];
            end
            OP_SWAP: r = {a[H-1:0], a[W-1:H]};
            default: r = a;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           is_div,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           fin,
    output logic [W-1:0]   res_lo,
    output logic [W-1:0]   res_hi,
    output logic           ov
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic              busy;
        logic              fin;
        logic              div;
        logic              dz;
        logic [CW-1:0]     cnt;
        logic [2*W-1:0]    p;
        logic [W-1:0]      m;
    } eng_t;

    eng_t         q_q;
    eng_t         q_d;
    logic [W:0]   shifted;
    logic [W:0]   diff;
    logic [W-1:0] addend;
    logic [W:0]   msum;

    always_comb begin
        q_d     = q_q;
        q_d.fin = 1'b0;
        shifted = {q_q.p[2*W-1:W], q_q.p[W-1]};
        diff    = shifted - {1'b0, q_q.m};
        addend  = q_q.p[0] ? q_q.m : '0;
        msum    = {1'b0, q_q.p[2*W-1:W]} + {1'b0, addend};
        if (go && !q_q.busy && !q_q.fin) begin
            q_d.div = is_div;
            q_d.m   = is_div ? b : a;
            q_d.p   = is_div ? {{W{1'b0}}, a} : {{W{1'b0}}, b};
            if (is_div && (b == '0)) begin
                q_d.dz   = 1'b1;
                q_d.fin  = 1'b1;
                q_d.busy = 1'b0;
                q_d.cnt  = '0;
            end else begin
                q_d.dz   = 1'b0;
                q_d.busy = 1'b1;
                q_d.cnt  = CW'(W);
            end
        end else if (q_q.busy) begin
            if (q_q.div) begin
                if (shifted >= {1'b0, q_q.m}) begin
                    q_d.p = {diff[W-1:0], q_q.p[W-2:0], 1'b1};
                end else begin
                    q_d.p = {shifted[W-1:0], q_q.p[W-2:0], 1'b0};
                end
            end else begin
                q_d.p = {msum, q_q.p[W-1:1]};
            end
            q_d.cnt = q_q.cnt - CW'(1);
            if (q_q.cnt == CW'(1)) begin
                q_d.busy = 1'b0;
                q_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign busy   = q_q.busy;
    assign fin    = q_q.fin;
    assign res_lo = q_q.p[W-1:0];
    assign res_hi = q_q.p[2*W-1:W];
    assign ov     = q_q.div ? q_q.dz : (|q_q.p[2*W-1:W]);

    // R12: completion is a single-cycle pulse
    a_r12_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // R12: a running engine always has steps left
    a_r12_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (q_q.cnt != '0));

    // R7: zero divisor finishes at once and flags overflow
    a_r7_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && !fin && is_div && (b == '0)) |=> (fin && ov && !busy));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [4:0]     op,
    input  logic [W-1:0]   acc_in,
    input  logic [W-1:0]   opnd_in,
    input  logic [W-1:0]   b_in,
    input  logic           cy_in,
    input  logic           ac_in,
    input  logic           ov_in,
    output logic [W-1:0]   acc_out,
    output logic [W-1:0]   b_out,
    output logic           cy_out,
    output logic           ac_out,
    output logic           ov_out,
    output logic           done,
    output logic           busy
);
    localparam int H = W / 2;

    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] b;
        alu_flags_t   fl;
        logic         done;
    } out_t;

    alu_op_e      op_e;
    alu_flags_t   fl_in;
    logic [W-1:0] ar_r;
    alu_flags_t   ar_f;
    logic [W-1:0] lg_r;
    alu_flags_t   lg_f;
    logic         eng_busy;
    logic         eng_fin;
    logic [W-1:0] eng_lo;
    logic [W-1:0] eng_hi;
    logic         eng_ov;
    logic         accept;
    logic         is_md;
    logic         is_logic;
    out_t         o_d;
    out_t         o_q;

    assign op_e     = alu_op_e'(op);
    assign fl_in    = '{cy: cy_in, ac: ac_in, ov: ov_in};
    assign accept   = start && !eng_busy && !eng_fin;
    assign is_md    = (op_e == OP_MUL) || (op_e == OP_DIV);
    assign is_logic = (op >= 5'(OP_AND)) && (op <= 5'(OP_SWAP));

    acc_alu_arith #(.W(W)) u_arith (
        .op (op_e),
        .a  (acc_in),
        .o  (opnd_in),
        .fi (fl_in),
        .r  (ar_r),
        .fo (ar_f)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op (op_e),
        .a  (acc_in),
        .o  (opnd_in),
        .fi (fl_in),
        .r  (lg_r),
        .fo (lg_f)
    );

    acc_alu_muldiv #(.W(W)) u_muldiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (accept && is_md),
        .is_div (op_e == OP_DIV),
        .a      (acc_in),
        .b      (b_in),
        .busy   (eng_busy),
        .fin    (eng_fin),
        .res_lo (eng_lo),
        .res_hi (eng_hi),
        .ov     (eng_ov)
    );

    always_comb begin
        o_d      = o_q;
        o_d.done = 1'b0;
        if (eng_fin) begin
            o_d.acc   = eng_lo;
            o_d.b     = eng_hi;
            o_d.fl.cy = 1'b0;
            o_d.fl.ac = 1'b0;
            o_d.fl.ov = eng_ov;
            o_d.done  = 1'b1;
        end else if (accept && !is_md) begin
            o_d.b    = b_in;
            o_d.done = 1'b1;
            if (is_logic) begin
                o_d.acc = lg_r;
                o_d.fl  = lg_f;
            end else begin
                o_d.acc = ar_r;
                o_d.fl  = ar_f;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign acc_out = o_q.acc;
    assign b_out   = o_q.b;
    assign cy_out  = o_q.fl.cy;
    assign ac_out  = o_q.fl.ac;
    assign ov_out  = o_q.fl.ov;
    assign done    = o_q.done;
    assign busy    = eng_busy | eng_fin;

    // R4: increment and decrement pass all flags through
    a_r4_incdec_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ((op_e == OP_INC) || (op_e == OP_DEC))) |=>
        (done && (cy_out == $past(cy_in)) && (ac_out == $past(ac_in)) && (ov_out == $past(ov_in))));

    // R11: nibble exchange
    a_r11_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (op_e == OP_SWAP)) |=>
        (acc_out == {$past(acc_in[H-1:0]), $past(acc_in[W-1:H])}));

    // R5: multiply and divide results leave carry clear
    a_r5_md_carry: assert property (@(posedge clk) disable iff (!rst_n)
        eng_fin |=> (done && !cy_out && !ac_out));

    // R12: nothing changes while the engine is stepping
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_fin) |=> (!done && $stable(acc_out) && $stable(b_out)));

    // R13: B follows the input for single-cycle codes
    a_r13_b_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_md) |=> (done && (b_out == $past(b_in))));

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;

    logic       clk;
    logic       rst_n;
    logic       start;
    logic [4:0] op;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic [7:0] b_in;
    logic       cy_in;
    logic       ac_in;
    logic       ov_in;
    logic [7:0] acc_out;
    logic [7:0] b_out;
    logic       cy_out;
    logic       ac_out;
    logic       ov_out;
    logic       done;
    logic       busy;

    int checks;
    int fails;

    acc_alu #(.W(8)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .acc_in  (acc_in),
        .opnd_in (opnd_in),
        .b_in    (b_in),
        .cy_in   (cy_in),
        .ac_in   (ac_in),
        .ov_in   (ov_in),
        .acc_out (acc_out),
        .b_out   (b_out),
        .cy_out  (cy_out),
        .ac_out  (ac_out),
        .ov_out  (ov_out),
        .done    (done),
        .busy    (busy)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] op_v, input logic [7:0] a, input logic [7:0] o,
                         input logic [7:0] bb, input logic c, input logic h, input logic v,
                         output int lat);
        op = op_v; acc_in = a; opnd_in = o; b_in = bb;
        cy_in = c; ac_in = h; ov_in = v;
        start = 1'b1;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end while (!done && lat < 40);
    endtask

    task automatic run_check(input string req, input logic [4:0] op_v,
                             input logic [7:0] a, input logic [7:0] o, input logic [7:0] bb,
                             input logic c, input logic h, input logic v,
                             input logic [7:0] e_acc, input logic [7:0] e_b,
                             input logic e_cy, input logic e_ac, input logic e_ov, input int e_lat);
        int lat;
        issue(op_v, a, o, bb, c, h, v, lat);
        chk(req, "latency", lat, e_lat);
        chk(req, "acc", acc_out, e_acc);
        chk(req, "b", b_out, e_b);
        chk(req, "cy", cy_out, e_cy);
        chk(req, "ac", ac_out, e_ac);
        chk(req, "ov", ov_out, e_ov);
    endtask

    function automatic logic [15:0] pair(input int i);
        case (i)
            0: return 16'h7F01;
            1: return 16'hFF01;
            2: return 16'h8080;
            3: return 16'h0F01;
            4: return 16'h1020;
            5: return 16'h8001;
            default: return 16'h00FF;
        endcase
    endfunction

    // R14: reset state
    task automatic t_reset();
        chk("R14", "acc", acc_out, 0);
        chk("R14", "b", b_out, 0);
        chk("R14", "flags", {cy_out, ac_out, ov_out}, 0);
        chk("R14", "done", done, 0);
        chk("R14", "busy", busy, 0);
    endtask

    // R1, R2, R3: add, add with carry, subtract with borrow
    task automatic t_addsub();
        for (int i = 0; i < 7; i++) begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] a;
                logic [7:0] o;
                int s, hs, sr, cin;
                a = pair(i)[15:8];
                o = pair(i)[7:0];
                // R1 plain add: carry-in ignored
                s  = a + o;
                hs = (a & 15) + (o & 15);
                sr = int'($signed(a)) + int'($signed(o));
                run_check("R1", 5'd0, a, o, 8'h33, c[0], 1'b0, 1'b0,
                          s[7:0], 8'h33, s > 255, hs > 15, (sr > 127) || (sr < -128), 1);
                // R1 add with carry
                cin = c;
                s  = a + o + cin;
                hs = (a & 15) + (o & 15) + cin;
                sr = int'($signed(a)) + int'($signed(o)) + cin;
                run_check("R1", 5'd1, a, o, 8'h44, c[0], 1'b0, 1'b0,
                          s[7:0], 8'h44, s > 255, hs > 15, (sr > 127) || (sr < -128), 1);
                // R2 / R3 subtract with borrow
                s  = a - o - cin;
                hs = (a & 15) - (o & 15) - cin;
                sr = int'($signed(a)) - int'($signed(o)) - cin;
                run_check("R2", 5'd2, a, o, 8'h55, c[0], 1'b1, 1'b0,
                          s[7:0], 8'h55, s < 0, hs < 0, (sr > 127) || (sr < -128), 1);
            end
        end
        // R3 named cases: half carry alone and signed overflow alone
        run_check("R3", 5'd0, 8'h0F, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h10, 8'h00, 1'b0, 1'b1, 1'b0, 1);
        run_check("R3", 5'd2, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 8'h7F, 8'h00, 1'b0, 1'b1, 1'b1, 1);
    endtask

    // R4: wrap without touching flags
    task automatic t_incdec();
        run_check("R4", 5'd3, 8'hFF, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1, 8'h00, 8'h11, 1'b1, 1'b0, 1'b1, 1);
        run_check("R4", 5'd4, 8'h00, 8'h00, 8'h11, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h11, 1'b0, 1'b1, 1'b0, 1);
        run_check("R4", 5'd3, 8'h41, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0, 8'h42, 8'h11, 1'b0, 1'b0, 1'b0, 1);
    endtask

    // R5, R12: multiply
    task automatic t_mul();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] a;
            logic [7:0] bb;
            logic [15:0] p;
            case (i)
                0: begin a = 8'hFF; bb = 8'hFF; end
                1: begin a = 8'h0C; bb = 8'h0A; end
                2: begin a = 8'h00; bb = 8'h55; end
                default: begin a = 8'h81; bb = 8'h02; end
            endcase
            p = 16'(a) * 16'(bb);
            run_check("R5", 5'd5, a, 8'h00, bb, 1'b1, 1'b1, 1'b0,
                      p[7:0], p[15:8], 1'b0, 1'b0, p[15:8] != 0, 10);
        end
    endtask

    // R6, R12: divide
    task automatic t_div();
        for (int i = 0; i < 3; i++) begin
            logic [7:0] a;
            logic [7:0] bb;
            case (i)
                0: begin a = 8'hFB; bb = 8'h12; end
                1: begin a = 8'hFF; bb = 8'h01; end
                default: begin a = 8'h05; bb = 8'h07; end
            endcase
            run_check("R6", 5'd6, a, 8'h00, bb, 1'b1, 1'b1, 1'b1,
                      a / bb, a % bb, 1'b0, 1'b0, 1'b0, 10);
        end
    endtask

    // R7: division by zero
    task automatic t_divzero();
        run_check("R7", 5'd6, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 8'h3C, 8'h00, 1'b0, 1'b0, 1'b1, 2);
    endtask

    // R8: decimal adjust
    task automatic t_dadj();
        run_check("R8", 5'd7, 8'h9A, 8'h00, 8'h07, 1'b0, 1'b0, 1'b0, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1);
        run_check("R8", 5'd7, 8'h81, 8'h00, 8'h07, 1'b0, 1'b1, 1'b1, 8'h87, 8'h07, 1'b0, 1'b1, 1'b1, 1);
        run_check("R8", 5'd7, 8'h12, 8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 8'h72, 8'h07, 1'b1, 1'b0, 1'b0, 1);
        run_check("R8", 5'd7, 8'h99, 8'h00, 8'h07, 1'b0, 1'b0, 1'b0, 8'h99, 8'h07, 1'b0, 1'b0, 1'b0, 1);
    endtask

    // R9: bitwise operations, complement and clear
    task automatic t_logic();
        logic [7:0] a;
        logic [7:0] o;
        a = 8'hC5;
        o = 8'h3C;
        run_check("R9", 5'd8,  a, o, 8'h99, 1'b1, 1'b1, 1'b0, a & o, 8'h99, 1'b1, 1'b1, 1'b0, 1);
        run_check("R9", 5'd9,  a, o, 8'h99, 1'b1, 1'b1, 1'b0, a | o, 8'h99, 1'b1, 1'b1, 1'b0, 1);
        run_check("R9", 5'd10, a, o, 8'h99, 1'b0, 1'b0, 1'b1, a ^ o, 8'h99, 1'b0, 1'b0, 1'b1, 1);
        run_check("R9", 5'd11, a, o, 8'h99, 1'b0, 1'b1, 1'b1, 8'd255 - a, 8'h99, 1'b0, 1'b1, 1'b1, 1);
        run_check("R9", 5'd12, a, o, 8'h99, 1'b1, 1'b0, 1'b1, 8'h00, 8'h99, 1'b1, 1'b0, 1'b1, 1);
    endtask

    // R10: rotates
    task automatic t_rot();
        run_check("R10", 5'd13, 8'h96, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 8'h2D, 8'h01, 1'b1, 1'b0, 1'b0, 1);
        run_check("R10", 5'd15, 8'h96, 8'h00, 8'h01, 1'b1, 1'b0, 1'b1, 8'h4B, 8'h01, 1'b1, 1'b0, 1'b1, 1);
        run_check("R10", 5'd14, 8'h96, 8'h00, 8'h01, 1'b0, 1'b1, 1'b0, 8'h2C, 8'h01, 1'b1, 1'b1, 1'b0, 1);
        run_check("R10", 5'd16, 8'h96, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 8'hCB, 8'h01, 1'b0, 1'b0, 1'b0, 1);
    endtask

    // R11: nibble swap
    task automatic t_swap();
        run_check("R11", 5'd17, 8'hA5, 8'h00, 8'h02, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h02, 1'b0, 1'b0, 1'b0, 1);
        run_check("R11", 5'd17, 8'h3C, 8'h00, 8'h02, 1'b1, 1'b1, 1'b1, 8'hC3, 8'h02, 1'b1, 1'b1, 1'b1, 1);
    endtask

    // R13: undefined codes pass through
    task automatic t_undef();
        run_check("R13", 5'd25, 8'h6E, 8'hFF, 8'h9D, 1'b1, 1'b0, 1'b1, 8'h6E, 8'h9D, 1'b1, 1'b0, 1'b1, 1);
        run_check("R13", 5'd31, 8'h01, 8'hFF, 8'h02, 1'b0, 1'b1, 1'b0, 8'h01, 8'h02, 1'b0, 1'b1, 1'b0, 1);
    endtask

    // R12: starts during a multiply are ignored
    task automatic t_busy();
        int bad_busy;
        int early_done;
        op = 5'd5; acc_in = 8'h10; opnd_in = 8'h00; b_in = 8'h10;
        cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b0;
        start = 1'b1;
        @(posedge clk);
        bad_busy = 0;
        early_done = 0;
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            op = 5'd0; acc_in = 8'h01; opnd_in = 8'h01; b_in = 8'h77;
            if (!busy) bad_busy++;
            if (done) early_done++;
        end
        @(negedge clk);
        start = 1'b0;
        chk("R12", "busy low during run", bad_busy, 0);
        chk("R12", "done during run", early_done, 0);
        chk("R12", "done at W+2", done, 1);
        chk("R12", "busy after done", busy, 0);
        chk("R12", "product low", acc_out, 8'h00);
        chk("R12", "product high", b_out, 8'h01);
        chk("R12", "product ov", ov_out, 1);
        @(negedge clk);
        chk("R12", "no extra done", done, 0);
        chk("R12", "acc held", acc_out, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        checks = 0;
        fails  = 0;
        rst_n = 1'b0; start = 1'b0; op = 5'd0;
        acc_in = 8'h00; opnd_in = 8'h00; b_in = 8'h00;
        cy_in = 1'b0; ac_in = 1'b0; ov_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addsub();
        t_incdec();
        t_mul();
        t_div();
        t_divzero();
        t_dadj();
        t_logic();
        t_rot();
        t_swap();
        t_undef();
        t_busy();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule